// File: doc/BRIEF.md
# TDM Sensor Array Bus Master

This block drives a shared TDM bus that serves a daisy chain of up to sixteen sensor nodes. It divides the system clock to make the bit clock and sends out a one-bit-clock-wide frame-sync pulse once per frame. Frame sync starts only after a programmable number of bit-clock periods has passed since the bit clock began. The frame length depends on how many nodes are present: the smallest power-of-two count of 32-bit slots that holds every node.

Nodes share one data line. A node launches each bit on a rising bit-clock edge, and this block captures that bit on the following rising edge. The block collects the first 24 bits of every slot into a signed sample. It reports that sample with a channel index and a one-cycle strobe, but only for slots that belong to a node that is present. When the enable input is low, the bus stops at once with both clocks held low. Enabling the bus again repeats the whole start-up sequence.

Top module: `tdm_array_master`

## Requirements
- R1: While reset is asserted, `sck`, `ws` and `smp_valid` are low.
- R2: While `run` is high, `sck` has a period of 2×HALF_DIV system clocks. It is low for the first HALF_DIV clocks after `run` is sampled high, and high for the following HALF_DIV clocks.
- R3: `ws` stays low for SYNC_DELAY full `sck` periods after the first rising edge of `sck`. It first goes high on rising edge number SYNC_DELAY, counting the first rising edge as number 0.
- R4: `ws` is high for exactly one `sck` period at the start of every frame, and it changes only together with a rising edge of `sck`.
- R5: The frame length in `sck` periods is 64 for a `node_count` of 1 or 2, 128 for 3 or 4, 256 for 5 to 8, and 512 for 9 to 16. `node_count` is sampled when each frame starts.
- R6: Let p be the frame position of an `sck` period, with p=0 for the period in which `ws` is high, and let L be the frame length. `sd_in` is sampled on the rising edge that begins period p, and that bit is bit q=(p−2) mod L of the frame stream. The bit belongs to slot q/32, at position q mod 32 within the slot, where position 0 is the first bit of the slot.
- R7: Slot positions 0 to 23 form a two's-complement sample with the MSB at position 0. Positions 24 to 31 have no effect on any output.
- R8: `smp_valid` pulses high for one system clock, together with the rising edge of `sck` that captures slot position 23. During that pulse, `smp_chan` gives the slot number and `smp_data` gives the 24-bit sample.
- R9: Slots numbered `node_count` or higher never raise `smp_valid`.
- R10: When `run` is low on a system clock edge, `sck`, `ws` and `smp_valid` are low after that edge and stay low. A later restart repeats the delay of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Bus enable; low stops and clears the bus |
| node_count | input | CNT_W (5) | Number of nodes present on the chain |
| sd_in | input | 1 | Shared serial data line |
| sck | output | 1 | Bit clock to the chain |
| ws | output | 1 | Frame-sync pulse to the first node |
| smp_valid | output | 1 | One-clock strobe for a captured sample |
| smp_chan | output | CH_W (4) | Slot number of the sample |
| smp_data | output | SAMPLE_BITS (24) | Two's-complement sample |

## Verification
The model of the node chain drives every slot, including unused ones, with a distinct value that depends on both the frame and the slot. This exposes any error in the slot index, the bit offset or the frame number. Positions 24 to 31 and all periods before frame sync carry ones, so leakage of ignored bits into a sample becomes visible. Full-scale negative and positive samples appear in some frames to test sign handling. Node counts of 1, 2, 3, 5, 9 and 16 cover every frame length, as well as dropped slots within both the shortest and the longest frame. Stops between runs test that the outputs go quiet and that the delay before frame sync starts again from zero.

// File: rtl/tdm_master_pkg.sv
package tdm_master_pkg;

   // last frame position (length-1) for a node count: smallest power of two
   // of slots, at least two, holding all nodes, capped at max_nodes
   function automatic int frame_last(input int count, input int max_nodes,
                                     input int slot_bits);
      int n;
      n = 2;
      for (int i = 0; i < 5; i++) begin
         if (n < count && n < max_nodes) n = n * 2;
      end
      return n * slot_bits - 1;
   endfunction

endpackage

// File: rtl/tdm_bitclk_gen.sv
module tdm_bitclk_gen #(
   parameter int HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sck,
   output logic rise_tick
);
   logic sck_q;
   assign sck = sck_q;

   generate
      if (HALF_DIV == 1) begin : g_direct
         assign rise_tick = run && !sck_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    sck_q <= 1'b0;
            else if (!run) sck_q <= 1'b0;
            else           sck_q <= ~sck_q;
         end
      end else begin : g_count
         localparam int DIV_W = $clog2(HALF_DIV);
         logic [DIV_W-1:0] div_q;
         logic             wrap;
         assign wrap      = (div_q == DIV_W'(HALF_DIV - 1));
         assign rise_tick = run && wrap && !sck_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div_q <= '0;
               sck_q <= 1'b0;
            end else if (!run) begin
               div_q <= '0;
               sck_q <= 1'b0;
            end else if (wrap) begin
               div_q <= '0;
               sck_q <= ~sck_q;
            end else begin
               div_q <= div_q + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/tdm_frame_ctl.sv
module tdm_frame_ctl
   import tdm_master_pkg::*;
#(
   parameter int MAX_NODES  = 16,
   parameter int SLOT_BITS  = 32,
   parameter int SYNC_DELAY = 30720,
   localparam int POS_W = $clog2(MAX_NODES * SLOT_BITS),
   localparam int CNT_W = $clog2(MAX_NODES + 1),
   localparam int DLY_W = $clog2(SYNC_DELAY + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             rise_tick,
   input  logic [CNT_W-1:0] node_count,
   output logic             ws,
   output logic             cap_en,
   output logic [POS_W-1:0] pos_nxt,
   output logic [POS_W-1:0] last_pos,
   output logic [CNT_W-1:0] cnt_lat
);
   logic             started_q;
   logic [DLY_W-1:0] dly_q;
   logic [POS_W-1:0] pos_q;
   logic [POS_W-1:0] new_last;

   assign new_last = POS_W'(frame_last(int'(node_count), MAX_NODES, SLOT_BITS));
   assign pos_nxt  = (pos_q == last_pos) ? '0 : pos_q + 1'b1;
   assign cap_en   = rise_tick && started_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         started_q <= 1'b0;
         dly_q     <= '0;
         pos_q     <= '0;
         last_pos  <= '0;
         cnt_lat   <= '0;
         ws        <= 1'b0;
      end else if (!run) begin
         started_q <= 1'b0;
         dly_q     <= '0;
         pos_q     <= '0;
         ws        <= 1'b0;
      end else if (rise_tick) begin
         if (!started_q) begin
            if (dly_q == DLY_W'(SYNC_DELAY)) begin
               started_q <= 1'b1;
               pos_q     <= '0;
               ws        <= 1'b1;
               last_pos  <= new_last;
               cnt_lat   <= node_count;
            end else begin
               dly_q <= dly_q + 1'b1;
            end
         end else begin
            pos_q <= pos_nxt;
            ws    <= (pos_nxt == '0);
            if (pos_nxt == '0) begin
               last_pos <= new_last;
               cnt_lat  <= node_count;
            end
         end
      end
   end
endmodule

// File: rtl/tdm_slot_deser.sv
module tdm_slot_deser #(
   parameter int MAX_NODES   = 16,
   parameter int SLOT_BITS   = 32,
   parameter int SAMPLE_BITS = 24,
   localparam int POS_W  = $clog2(MAX_NODES * SLOT_BITS),
   localparam int SLOT_W = $clog2(SLOT_BITS),
   localparam int CH_W   = $clog2(MAX_NODES),
   localparam int CNT_W  = $clog2(MAX_NODES + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   run,
   input  logic                   cap_en,
   input  logic                   sd_in,
   input  logic [POS_W-1:0]       pos_nxt,
   input  logic [POS_W-1:0]       last_pos,
   input  logic [CNT_W-1:0]       cnt_lat,
   output logic                   smp_valid,
   output logic [CH_W-1:0]        smp_chan,
   output logic [SAMPLE_BITS-1:0] smp_data
);
   logic [POS_W-1:0]       bit_q;
   logic [CH_W-1:0]        slot;
   logic [SLOT_W-1:0]      offs;
   logic [SAMPLE_BITS-1:0] shreg;
   logic [SAMPLE_BITS-1:0] shifted;

   // the bit captured now was launched one period earlier and belongs to
   // stream position pos_nxt-2 modulo the frame length
   assign bit_q   = (pos_nxt >= POS_W'(2)) ? pos_nxt - POS_W'(2)
                                           : last_pos - POS_W'(1) + pos_nxt;
   assign slot    = bit_q[POS_W-1:SLOT_W];
   assign offs    = bit_q[SLOT_W-1:0];
   assign shifted = {shreg[SAMPLE_BITS-2:0], sd_in};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg     <= '0;
         smp_valid <= 1'b0;
         smp_chan  <= '0;
         smp_data  <= '0;
      end else if (!run) begin
         shreg     <= '0;
         smp_valid <= 1'b0;
      end else begin
         smp_valid <= 1'b0;
         if (cap_en && offs < SLOT_W'(SAMPLE_BITS)) begin
            shreg <= shifted;
            if (offs == SLOT_W'(SAMPLE_BITS - 1) &&
                CNT_W'(slot) < cnt_lat) begin
               smp_valid <= 1'b1;
               smp_chan  <= slot;
               smp_data  <= shifted;
            end
         end
      end
   end
endmodule

// File: rtl/tdm_array_master.sv
module tdm_array_master #(
   parameter int MAX_NODES   = 16,
   parameter int SLOT_BITS   = 32,
   parameter int SAMPLE_BITS = 24,
   parameter int HALF_DIV    = 2,
   parameter int SYNC_DELAY  = 30720,
   localparam int POS_W = $clog2(MAX_NODES * SLOT_BITS),
   localparam int CH_W  = $clog2(MAX_NODES),
   localparam int CNT_W = $clog2(MAX_NODES + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   run,
   input  logic [CNT_W-1:0]       node_count,
   input  logic                   sd_in,
   output logic                   sck,
   output logic                   ws,
   output logic                   smp_valid,
   output logic [CH_W-1:0]        smp_chan,
   output logic [SAMPLE_BITS-1:0] smp_data
);
   if (MAX_NODES != 2 && MAX_NODES != 4 && MAX_NODES != 8 && MAX_NODES != 16)
      begin : g_bad_nodes
      $error("MAX_NODES must be 2, 4, 8 or 16");
   end
   if ((SLOT_BITS & (SLOT_BITS - 1)) != 0 || SAMPLE_BITS < 2 ||
       SAMPLE_BITS > SLOT_BITS) begin : g_bad_slot
      $error("SLOT_BITS must be a power of two holding SAMPLE_BITS");
   end
   if (HALF_DIV < 1 || SYNC_DELAY < 0) begin : g_bad_timing
      $error("HALF_DIV must be at least 1 and SYNC_DELAY non-negative");
   end

   logic             rise_tick;
   logic             cap_en;
   logic [POS_W-1:0] pos_nxt;
   logic [POS_W-1:0] last_pos;
   logic [CNT_W-1:0] cnt_lat;

   tdm_bitclk_gen #(.HALF_DIV(HALF_DIV)) u_clk (
      .clk(clk), .rst_n(rst_n), .run(run), .sck(sck), .rise_tick(rise_tick)
   );

   tdm_frame_ctl #(
      .MAX_NODES(MAX_NODES), .SLOT_BITS(SLOT_BITS), .SYNC_DELAY(SYNC_DELAY)
   ) u_frm (
      .clk(clk), .rst_n(rst_n), .run(run), .rise_tick(rise_tick),
      .node_count(node_count), .ws(ws), .cap_en(cap_en),
      .pos_nxt(pos_nxt), .last_pos(last_pos), .cnt_lat(cnt_lat)
   );

   tdm_slot_deser #(
      .MAX_NODES(MAX_NODES), .SLOT_BITS(SLOT_BITS), .SAMPLE_BITS(SAMPLE_BITS)
   ) u_des (
      .clk(clk), .rst_n(rst_n), .run(run), .cap_en(cap_en), .sd_in(sd_in),
      .pos_nxt(pos_nxt), .last_pos(last_pos), .cnt_lat(cnt_lat),
      .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_data(smp_data)
   );
endmodule

// File: rtl/tdm_array_master_chk.sv
module tdm_array_master_chk #(
   parameter int CH_W  = 4,
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             sck,
   input logic             ws,
   input logic             smp_valid,
   input logic [CH_W-1:0]  smp_chan,
   input logic [CNT_W-1:0] cnt_lat
);
   // R4
   ws_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && ws != $past(ws)) |-> $rose(sck));
   // R8
   valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |=> !smp_valid);
   // R8
   valid_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |-> $rose(sck));
   // R9
   chan_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |-> (CNT_W'(smp_chan) < cnt_lat));
   // R10
   stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!sck && !ws && !smp_valid));
endmodule

bind tdm_array_master tdm_array_master_chk #(.CH_W(CH_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .run(run), .sck(sck), .ws(ws),
   .smp_valid(smp_valid), .smp_chan(smp_chan), .cnt_lat(cnt_lat)
);

// File: tb/tdm_array_master_tb_top.sv
`timescale 1ns/1ps
module tdm_array_master_tb_top;
   localparam int H = 2;
   localparam int D = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run = 1'b0;
   logic [4:0]  node_count = 5'd2;
   logic        sd_in = 1'b1;
   logic        sck, ws, smp_valid;
   logic [3:0]  smp_chan;
   logic [23:0] smp_data;

   int checks = 0;
   int errors = 0;
   int ecnt = 0;
   bit done = 0;

   always #2 clk = ~clk;

   tdm_array_master #(.HALF_DIV(H), .SYNC_DELAY(D)) dut_i (
      .clk(clk), .rst_n(rst_n), .run(run), .node_count(node_count),
      .sd_in(sd_in), .sck(sck), .ws(ws), .smp_valid(smp_valid),
      .smp_chan(smp_chan), .smp_data(smp_data)
   );

   function automatic int len_for(input int n);
      if (n <= 2) return 64;
      if (n <= 4) return 128;
      if (n <= 8) return 256;
      return 512;
   endfunction

   function automatic logic [23:0] pat(input int f, input int s);
      if (f % 3 == 1 && s == 0) return 24'h800000;
      if (f % 3 == 1 && s == 1) return 24'h7FFFFF;
      return 24'((f + 1) * 24'h0B3D17 + (s + 3) * 24'h2E4C91);
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t",
                  tag, what, act, exp, $time);
      end
   endtask

   // posedges seen with run high since it last rose
   always @(posedge clk) begin
      if (rst_n && run) ecnt <= ecnt + 1;
      else ecnt <= 0;
   end

   // behavioural model of bus timing and node chain, compared every clock
   always @(negedge clk) begin
      int e, k, rel, p, L, q, f, sl, b;
      bit rose, exp_sck, exp_ws, exp_v;
      logic [23:0] exp_d;
      int exp_c;
      if (rst_n) begin
         e = ecnt;
         L = len_for(int'(node_count));
         exp_sck = 0; exp_ws = 0; exp_v = 0; exp_d = '0; exp_c = 0; rose = 0;
         k = -1;
         if (e > 0) begin
            exp_sck = (e % (2 * H)) >= H;
            rose    = (e % (2 * H)) == H;
            k       = (e + H) / (2 * H) - 1;
            if (k >= D) begin
               rel    = k - D;
               exp_ws = (rel % L) == 0;
               if (rose && rel >= 2) begin
                  q  = (rel - 2) % L;
                  f  = (rel - 2) / L;
                  sl = q / 32;
                  if (q % 32 == 23 && sl < int'(node_count)) begin
                     exp_v = 1;
                     exp_c = sl;
                     exp_d = pat(f, sl);
                  end
               end
               if (rose) begin
                  if (rel == 0) sd_in <= 1'b1;
                  else begin
                     p  = (rel - 1) % L;
                     f  = (rel - 1) / L;
                     sl = p / 32;
                     b  = p % 32;
                     sd_in <= (b < 24) ? pat(f, sl)[23 - b] : 1'b1;
                  end
               end
            end else if (rose) sd_in <= 1'b1;
         end
         // R2 bit clock shape; R10 quiet when stopped
         chk(sck === exp_sck, (e == 0) ? "R10" : "R2", "sck", 32'(sck), 32'(exp_sck));
         // R3 delay before first frame sync; R4 pulse width; R5 frame length
         chk(ws === exp_ws, (k < D) ? "R3" : "R4/R5", "ws", 32'(ws), 32'(exp_ws));
         // R6 capture offset, R8 strobe timing, R9 dropped slots
         chk(smp_valid === exp_v, "R8/R9", "smp_valid", 32'(smp_valid), 32'(exp_v));
         if (exp_v && smp_valid) begin
            chk(smp_chan === 4'(exp_c), "R8", "smp_chan", 32'(smp_chan), 32'(exp_c));
            // R6 slot bit order, R7 MSB first and ignored tail bits
            chk(smp_data === exp_d, "R6/R7", "smp_data", 32'(smp_data), 32'(exp_d));
         end
      end
   end

   task automatic segment(input int n, input int frames);
      @(negedge clk);
      node_count = 5'(n);
      run = 1'b1;
      repeat ((D + len_for(n) * frames + 3) * 2 * H) @(negedge clk);
      run = 1'b0;
      repeat (24) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 outputs quiet in reset
      chk(sck === 1'b0, "R1", "sck", 32'(sck), 0);
      chk(ws === 1'b0, "R1", "ws", 32'(ws), 0);
      chk(smp_valid === 1'b0, "R1", "smp_valid", 32'(smp_valid), 0);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      segment(2, 3);    // R5 64-period frame, both slots used
      segment(1, 3);    // R9 slot 1 dropped
      segment(3, 3);    // R5 128 periods, R9 slot 3 dropped
      segment(5, 2);    // R5 256 periods
      segment(9, 2);    // R5 512 periods, R9 slots 9..15 dropped
      segment(16, 2);   // full chain
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule